// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers six single-cycle event pulses (a timer expiry, transmit done, receive done, an idle indication, and high and low FIFO watermark alerts) into one latched request register. A second register holds one enable per source. The combined status output is high whenever any latched request has its enable set. Software reaches both registers, and a small pin-configuration register, through a simple synchronous write port and a combinational read port.

Neither the request register nor the enable register is written directly. Bit 7 of a write selects the action. When it is 1, every data bit in 5..0 that is 1 sets the matching register bit. When it is 0, every such bit clears its register bit. Bits written as 0 leave their register bits alone. The status drives an interrupt pin through an output stage. That stage can invert the pin and can act as a push-pull driver or an open-drain driver, with a separate output-enable.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the request and enable registers read 00h and the pin-configuration register reads 02h. In that state `irqStatus` is 0, `irqPin` is 0 and `irqPinOe` is 1.
- R2: A write to address 0 with data bit 7 = 1 sets each request bit whose data bit (5..0) is 1 and leaves every other bit unchanged. The new value reads back on the next cycle.
- R3: A write to address 0 with data bit 7 = 0 clears each request bit whose data bit is 1 and leaves every other bit unchanged. Writing 00h changes nothing.
- R4: The enable register at address 1 follows the same bit-7 set/clear rule and uses the same bit positions as the request register.
- R5: A one-cycle pulse on `evPulse[i]` sets request bit i on the next clock edge. The bit stays set with no further events until software clears it. The sources map to bits as follows: 5 timer, 4 transmit, 3 receive, 2 idle, 1 high alert, 0 low alert.
- R6: `irqStatus` is 1 exactly when some request bit and its enable bit are both 1. It follows a register change in the same cycle.
- R7: An event pulse in the same cycle as a software clear of that bit leaves the bit set. Other bits named in the same clear are still cleared.
- R8: Bits 7 and 6 of the request and enable registers read 0. The pin-configuration register (address 2) keeps only bits 1..0, and its other bits read 0. Address 3 reads 00h.
- R9: Pin-configuration bit 0 is the invert control. With bit 0 = 0 the pin level equals `irqStatus`. With bit 0 = 1 the pin level is the inverse of `irqStatus`.
- R10: Pin-configuration bit 1 selects the output stage. With bit 1 = 1 (push-pull), `irqPinOe` is 1 and `irqPin` equals the pin level. With bit 1 = 0 (open-drain), `irqPin` is 0, and `irqPinOe` is 1 only while the pin level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 request, 1 enable, 2 pin config) |
| regWrData | input | 8 | Write data; bit 7 is the set/clear selector for addresses 0 and 1 |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| evPulse | input | 6 | Event pulses, bit positions as in the request register |
| irqStatus | output | 1 | Combined enabled-request status |
| irqPin | output | 1 | Interrupt pin data |
| irqPinOe | output | 1 | Interrupt pin output-enable |

## Verification
A write or an event pulse passes through exactly one register stage. Its effect on `regRdData`, `irqStatus` and the pin outputs is therefore due at the first clock edge after the stimulus cycle. The bench changes inputs on the falling edge and holds them for one full cycle, then samples at the next falling edge, after the rising edge has taken effect. Configuration changes act on the pin combinationally from the configuration register, so they are sampled at that same falling edge. The collision case drives the event and the clear in one cycle to probe the priority rule.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC   = 6;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int CFG_W     = 2;
  localparam int SET_BIT   = 7;
  localparam logic [ADDR_W-1:0] ADDR_REQ = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd2;
  localparam logic [CFG_W-1:0]  CFG_RESET = 2'b10;

  typedef struct packed {
    logic               wrReq;
    logic               wrEna;
    logic               wrCfg;
    logic               setMode;
    logic [NUM_SRC-1:0] mask;
    logic [CFG_W-1:0]   cfgData;
  } regStrobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] reqVal,
  input  logic [NUM_SRC-1:0] enaVal,
  input  logic [CFG_W-1:0]   cfgVal,
  output regStrobe_t         strb,
  output logic [DATA_W-1:0]  regRdData
);
  localparam int PAD_SRC = DATA_W - NUM_SRC;
  localparam int PAD_CFG = DATA_W - CFG_W;

  logic unusedWrBits;
  assign unusedWrBits = ^regWrData[SET_BIT-1:NUM_SRC];

  always_comb begin
    strb         = '0;
    strb.wrReq   = regWrEn && (regAddr == ADDR_REQ);
    strb.wrEna   = regWrEn && (regAddr == ADDR_ENA);
    strb.wrCfg   = regWrEn && (regAddr == ADDR_CFG);
    strb.setMode = regWrData[SET_BIT];
    strb.mask    = regWrData[NUM_SRC-1:0];
    strb.cfgData = regWrData[CFG_W-1:0];
  end

  always_comb begin
    unique case (regAddr)
      ADDR_REQ: regRdData = {{PAD_SRC{1'b0}}, reqVal};
      ADDR_ENA: regRdData = {{PAD_SRC{1'b0}}, enaVal};
      ADDR_CFG: regRdData = {{PAD_CFG{1'b0}}, cfgVal};
      default:  regRdData = '0;
    endcase
  end

  // R2 R3 R4: at most one register strobed per write
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrReq, strb.wrEna, strb.wrCfg}));

  // R8: unused address never returns data
  p_spare_addr_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData == '0));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_SRC-1:0] evPulse,
  output logic [NUM_SRC-1:0] reqVal,
  output logic [NUM_SRC-1:0] enaVal,
  output logic [CFG_W-1:0]   cfgVal,
  output logic               irqStatus,
  output logic               irqPin,
  output logic               irqPinOe
);
  logic pinLevel;
  logic invertCfg;
  logic pushPullCfg;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic reqSet, reqClr, enaSet, enaClr;
    assign reqSet = strb.wrReq && strb.mask[i] && strb.setMode;
    assign reqClr = strb.wrReq && strb.mask[i] && !strb.setMode;
    assign enaSet = strb.wrEna && strb.mask[i] && strb.setMode;
    assign enaClr = strb.wrEna && strb.mask[i] && !strb.setMode;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqVal[i] <= 1'b0;
        enaVal[i] <= 1'b0;
      end else begin
        // hardware event outranks a software clear
        reqVal[i] <= evPulse[i] | reqSet | (reqVal[i] & ~reqClr);
        enaVal[i] <= enaSet | (enaVal[i] & ~enaClr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cfgVal <= CFG_RESET;
    else if (strb.wrCfg) cfgVal <= strb.cfgData;
  end

  assign invertCfg   = cfgVal[0];
  assign pushPullCfg = cfgVal[1];
  assign irqStatus   = |(reqVal & enaVal);
  assign pinLevel    = irqStatus ^ invertCfg;
  assign irqPin      = pushPullCfg ? pinLevel : 1'b0;
  assign irqPinOe    = pushPullCfg | ~pinLevel;

  // R5 R7: every pulsed source is latched on the next edge
  p_event_latched_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|evPulse) |=> ((reqVal & $past(evPulse)) == $past(evPulse)));

  // R2: set mask lands
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrReq && strb.setMode) |=> ((reqVal & $past(strb.mask)) == $past(strb.mask)));

  // R3: clear mask lands except where an event arrived
  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrReq && !strb.setMode) |=> ((reqVal & $past(strb.mask & ~evPulse)) == '0));

  // R5: requests hold with no write and no event
  p_req_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrReq && evPulse == '0) |=> $stable(reqVal));

  // R6: nothing enabled means no status
  p_no_enable_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enaVal == '0) |-> !irqStatus);

  // R10: an open-drain pin never drives high
  p_od_never_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgVal[1] && irqPinOe) |-> !irqPin);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evPulse,
  output logic               irqStatus,
  output logic               irqPin,
  output logic               irqPinOe
);
  regStrobe_t         strb;
  logic [NUM_SRC-1:0] reqVal;
  logic [NUM_SRC-1:0] enaVal;
  logic [CFG_W-1:0]   cfgVal;

  irq_agg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqVal(reqVal), .enaVal(enaVal),
    .cfgVal(cfgVal), .strb(strb), .regRdData(regRdData)
  );

  irq_agg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evPulse(evPulse),
    .reqVal(reqVal), .enaVal(enaVal), .cfgVal(cfgVal),
    .irqStatus(irqStatus), .irqPin(irqPin), .irqPinOe(irqPinOe)
  );
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [5:0] evPulse = 6'h00;
  logic       irqStatus, irqPin, irqPinOe;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evPulse(evPulse),
    .irqStatus(irqStatus), .irqPin(irqPin), .irqPinOe(irqPinOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one write, inputs applied on a falling edge, result visible at the next one
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pinCheck(input string tag, input logic st, input logic p, input logic oe);
    #1;
    check({tag, " status"}, {7'd0, irqStatus}, {7'd0, st});
    check({tag, " pin"}, {7'd0, irqPin}, {7'd0, p});
    check({tag, " oe"}, {7'd0, irqPinOe}, {7'd0, oe});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 req reset", d, 8'h00);
    rd(2'd1, d); check("R1 ena reset", d, 8'h00);
    rd(2'd2, d); check("R1 cfg reset", d, 8'h02);
    pinCheck("R1 pin reset", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sw_set_clear;
    logic [7:0] d;
    wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 set 25", d, 8'h25);
    wr(2'd0, 8'h82); rd(2'd0, d); check("R2 set adds bit1", d, 8'h27);
    wr(2'd0, 8'h04); rd(2'd0, d); check("R3 clear bit2", d, 8'h23);
    wr(2'd0, 8'h21); rd(2'd0, d); check("R3 clear two", d, 8'h02);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R3 zero write no change", d, 8'h02);
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R8 upper bits read 0", d, 8'h3F);
    wr(2'd0, 8'h3F); rd(2'd0, d); check("R3 clear all", d, 8'h00);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    wr(2'd1, 8'h8A); rd(2'd1, d); check("R4 ena set", d, 8'h0A);
    wr(2'd1, 8'h08); rd(2'd1, d); check("R4 ena clear", d, 8'h02);
    wr(2'd1, 8'hC0); rd(2'd1, d); check("R8 ena bit6 ignored", d, 8'h02);
    wr(2'd1, 8'h02); rd(2'd1, d); check("R4 ena clear all", d, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] d;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); evPulse = 6'(1 << i);
      @(negedge clk); evPulse = 6'h00;
      rd(2'd0, d); check($sformatf("R5 event bit %0d", i), d & 8'(1 << i), 8'(1 << i));
    end
    wr(2'd0, 8'h3D);
    repeat (5) @(negedge clk);
    rd(2'd0, d); check("R5 high alert held", d, 8'h02);
    wr(2'd0, 8'h02); rd(2'd0, d); check("R5 high alert cleared", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(2'd0, 8'h81);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h09; evPulse = 6'h08;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00; evPulse = 6'h00;
    rd(2'd0, d); check("R7 event beats clear", d, 8'h08);
    wr(2'd0, 8'h08);
  endtask

  task automatic t_status;
    wr(2'd0, 8'h84);
    pinCheck("R6 not enabled", 1'b0, 1'b0, 1'b1);
    wr(2'd1, 8'h84);
    pinCheck("R6 enabled", 1'b1, 1'b1, 1'b1);
    wr(2'd1, 8'h04);
    pinCheck("R6 enable removed", 1'b0, 1'b0, 1'b1);
    wr(2'd1, 8'h84);
  endtask

  task automatic t_pin;
    logic [7:0] d;
    wr(2'd2, 8'h03); pinCheck("R9 inverted push-pull", 1'b1, 1'b0, 1'b1);
    wr(2'd2, 8'h01); pinCheck("R10 od level low drives", 1'b1, 1'b0, 1'b1);
    wr(2'd2, 8'h00); pinCheck("R10 od level high released", 1'b1, 1'b0, 1'b0);
    wr(2'd0, 8'h04); pinCheck("R10 od status low drives", 1'b0, 1'b0, 1'b1);
    wr(2'd2, 8'h03); pinCheck("R9 inverted idle high", 1'b0, 1'b1, 1'b1);
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R8 cfg width", d, 8'h03);
    rd(2'd3, d); check("R8 spare address", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_set_clear();
    t_enable();
    t_events();
    t_collide();
    t_status();
    t_pin();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule